// File: doc/BRIEF.md
# Serial Adapter Status and Interrupt Logic

This block holds the status byte and drives the interrupt request line of a byte-wide asynchronous serial adapter that sits on a microprocessor bus. The receiver and transmitter report single-cycle event pulses: a character moved into the receive data register, together with that character's framing and parity flags, and the transmit data register handed to the shifter. The block combines these pulses with the active-low modem lines and with the interrupt enables. From them it produces an 8-bit status byte and an active-low interrupt output.

Bus accesses reach the block as raw strobes: two active-high chip selects, one active-low chip select, a register select, a read/write line and an enable. Reads and writes of the status and data registers have side effects. These side effects happen once per access, in the clock cycle after the enable falls. Both modem inputs pass through a synchronizer before they are used.

Top module: `serial_status_irq`

## Requirements
- R1: An access counts only while `bus_en` is high, `cs_hi` is 2'b11 and `cs_lo_n` is low. Its side effect happens once, after `bus_en` falls. `reg_sel`=0 with `rd_wr_n`=1 is a status read. `reg_sel`=1 with `rd_wr_n`=1 is a data read. `reg_sel`=1 with `rd_wr_n`=0 is a data write. A status read changes no status bit.
- R2: Status bit 0 (receive full) sets on `rx_load` and clears on a data read.
- R3: Status bit 1 (transmit empty) sets on `tx_taken` and clears on a data write. Status bit 3 follows `cts_n`, and that includes the time during reset. While `cts_n` is high, bit 1 reads 0.
- R4: A rising edge on `dcd_n` latches status bit 2. Only a status read followed by a data read clears the latch; a data read alone leaves it set. Once the latch is clear, bit 2 follows `dcd_n`.
- R5: Bit 0 reads 0 while `dcd_n` is high, but the received character stays held.
- R6: At each `rx_load`, bit 4 (framing) and bit 6 (parity) capture the error inputs. They hold those values until the next `rx_load`. Bit 6 reads 0 while `parity_en` is low.
- R7: An `rx_load` that arrives while bit 0 is set is an overrun. Bit 5 stays 0 until the next data read. After that read, bit 5 is 1 and bit 0 stays 1. The following data read clears both bits.
- R8: The receive interrupt is active when `rx_irq_en` is high and any of these holds: bit 0 is set, bit 5 is set, or the DCD latch is set.
- R9: The transmit interrupt is active when `tx_irq_en` is high and bit 1 is set. A data write removes it.
- R10: Status bit 7 is the inverse of `irq_n`. `irq_n` goes low when either interrupt is active.
- R11: After reset, with `cts_n` and `dcd_n` low and both interrupt enables off, the status byte reads 8'h02 and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low |
| cs_hi | input | 2 | Active-high chip selects |
| cs_lo_n | input | 1 | Active-low chip select |
| reg_sel | input | 1 | 0 selects status/control, 1 selects data |
| rd_wr_n | input | 1 | 1 for read, 0 for write |
| bus_en | input | 1 | Bus enable strobe |
| rx_load | input | 1 | Pulse: received character moved into the receive data register |
| rx_frame_err | input | 1 | Framing flag of that character, valid with rx_load |
| rx_parity_err | input | 1 | Parity flag of that character, valid with rx_load |
| tx_taken | input | 1 | Pulse: transmit data register handed to the shifter |
| cts_n | input | 1 | Clear-to-send, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| rx_irq_en | input | 1 | Receive interrupt enable |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| parity_en | input | 1 | Parity checking enabled |
| status | output | 8 | Status byte |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with the default synchronizer depth of two stages. Each modem edge therefore reaches the status byte within a fixed, short delay, which the bench waits out before it compares values. With that latency known, the bench can order modem edges precisely against bus accesses. This reaches the corner cases that depend on sequence: the DCD latch held through a data read that had no status read before it, a DCD bit that follows the input after the latch has cleared, CTS that is visible while reset is held, and the two-read overrun reveal.

// File: rtl/serial_status_irq.sv
module serial_status_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cs_hi,
  input  logic       cs_lo_n,
  input  logic       reg_sel,
  input  logic       rd_wr_n,
  input  logic       bus_en,
  input  logic       rx_load,
  input  logic       rx_frame_err,
  input  logic       rx_parity_err,
  input  logic       tx_taken,
  input  logic       cts_n,
  input  logic       dcd_n,
  input  logic       rx_irq_en,
  input  logic       tx_irq_en,
  input  logic       parity_en,
  output logic [7:0] status,
  output logic       irq_n
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] cts_sh, dcd_sh;
  logic cts_s, dcd_s, dcd_prev;

  always_ff @(posedge clk) begin
    cts_sh[0] <= cts_n;
    dcd_sh[0] <= dcd_n;
    for (int i = 1; i < SYNC_STAGES; i++) begin
      cts_sh[i] <= cts_sh[i-1];
      dcd_sh[i] <= dcd_sh[i-1];
    end
    dcd_prev <= dcd_sh[LAST];
  end

  assign cts_s = cts_sh[LAST];
  assign dcd_s = dcd_sh[LAST];

  logic qual, acc_q, rs_q, rw_q, fall;
  logic stat_rd, data_rd, data_wr, dcd_rise;

  assign qual = bus_en && (cs_hi == 2'b11) && !cs_lo_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      rs_q  <= 1'b0;
      rw_q  <= 1'b1;
    end else begin
      acc_q <= qual;
      if (qual) begin
        rs_q <= reg_sel;
        rw_q <= rd_wr_n;
      end
    end
  end

  assign fall     = acc_q && !bus_en;
  assign stat_rd  = fall && !rs_q && rw_q;
  assign data_rd  = fall && rs_q && rw_q;
  assign data_wr  = fall && rs_q && !rw_q;
  assign dcd_rise = dcd_s && !dcd_prev;

  logic rdrf, tdre, ovr_pend, ovr_show, fe, pe, dcd_lat, dcd_arm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdrf     <= 1'b0;
      tdre     <= 1'b1;
      ovr_pend <= 1'b0;
      ovr_show <= 1'b0;
      fe       <= 1'b0;
      pe       <= 1'b0;
      dcd_lat  <= 1'b0;
      dcd_arm  <= 1'b0;
    end else begin
      if (stat_rd) dcd_arm <= 1'b1;
      if (data_rd) dcd_arm <= 1'b0;
      if (dcd_rise) dcd_lat <= 1'b1;
      else if (data_rd && dcd_arm) dcd_lat <= 1'b0;

      if (data_wr) tdre <= 1'b0;
      if (tx_taken) tdre <= 1'b1;

      if (data_rd) begin
        if (ovr_pend) begin
          ovr_pend <= 1'b0;
          ovr_show <= 1'b1;
        end else begin
          ovr_show <= 1'b0;
          rdrf     <= 1'b0;
        end
      end
      if (rx_load) begin
        if (rdrf && !(data_rd && !ovr_pend)) begin
          ovr_pend <= 1'b1;
        end else begin
          rdrf <= 1'b1;
          fe   <= rx_frame_err;
          pe   <= rx_parity_err;
        end
      end
    end
  end

  logic rdrf_vis, tdre_vis, rx_irq, tx_irq;

  assign rdrf_vis = rdrf && !dcd_s;
  assign tdre_vis = tdre && !cts_s;
  assign rx_irq   = rx_irq_en && (rdrf_vis || ovr_show || dcd_lat);
  assign tx_irq   = tx_irq_en && tdre_vis;
  assign irq_n    = !(rx_irq || tx_irq);

  assign status = {!irq_n, pe && parity_en, ovr_show, fe,
                   cts_s, dcd_lat || dcd_s, tdre_vis, rdrf_vis};

endmodule

module serial_status_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cs_hi,
  input logic       cs_lo_n,
  input logic       reg_sel,
  input logic       rd_wr_n,
  input logic       bus_en,
  input logic       tx_taken,
  input logic       rx_irq_en,
  input logic       tx_irq_en,
  input logic       parity_en,
  input logic [7:0] status,
  input logic       irq_n
);
  logic en_q, rs_q, rw_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      rs_q <= 1'b0;
      rw_q <= 1'b1;
    end else begin
      en_q <= bus_en && cs_hi == 2'b11 && !cs_lo_n;
      if (bus_en) begin
        rs_q <= reg_sel;
        rw_q <= rd_wr_n;
      end
    end
  end
  logic rd_end, wr_end;
  assign rd_end = en_q && !bus_en && rs_q && rw_q;
  assign wr_end = en_q && !bus_en && rs_q && !rw_q;

  a_r3_cts_masks_tdre: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] |-> !status[1]);
  a_r3_write_clears_tdre: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_end && !tx_taken) |=> !status[1]);
  a_r6_parity_off: assert property (@(posedge clk) disable iff (!rst_n)
    !parity_en |-> !status[6]);
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_irq_en && !tx_irq_en) |-> irq_n);
  a_r7_ovrn_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[5]) |-> $past(rd_end));
endmodule

bind serial_status_irq serial_status_irq_chk i_chk (.*);

// File: tb/test_serial_status_irq.sv
module test_serial_status_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cs_hi = 2'b11;
  logic cs_lo_n = 1'b0, reg_sel = 1'b0, rd_wr_n = 1'b1, bus_en = 1'b0;
  logic rx_load = 1'b0, rx_frame_err = 1'b0, rx_parity_err = 1'b0, tx_taken = 1'b0;
  logic cts_n = 1'b0, dcd_n = 1'b0;
  logic rx_irq_en = 1'b0, tx_irq_en = 1'b0, parity_en = 1'b1;
  logic [7:0] status;
  logic irq_n;

  always #2.5 clk = ~clk;

  serial_status_irq i_serial_status_irq (.*);

  typedef struct { logic [7:0] val; string req; } exp_t;
  exp_t q[$];
  int tests = 0, fails = 0;
  int cyc = 0;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      tests++;
      if (status !== e.val) begin
        fails++;
        $display("FAIL %s status=%h expected=%h", e.req, status, e.val);
      end
      tests++;
      if (irq_n !== !e.val[7]) begin
        fails++;
        $display("FAIL R10 (%s) irq_n=%b expected=%b", e.req, irq_n, !e.val[7]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic expect_st(input logic [7:0] v, input string r);
    exp_t e;
    repeat (4) @(negedge clk);
    e.val = v;
    e.req = r;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic bus_begin(input logic rs, input logic rw);
    @(negedge clk);
    reg_sel = rs;
    rd_wr_n = rw;
    bus_en = 1'b1;
  endtask

  task automatic bus_end();
    repeat (2) @(negedge clk);
    bus_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic access(input logic rs, input logic rw);
    bus_begin(rs, rw);
    bus_end();
  endtask

  task automatic rx_char(input logic f, input logic p);
    @(negedge clk);
    rx_load = 1'b1;
    rx_frame_err = f;
    rx_parity_err = p;
    @(negedge clk);
    rx_load = 1'b0;
    rx_frame_err = 1'b0;
    rx_parity_err = 1'b0;
  endtask

  task automatic tx_pulse();
    @(negedge clk);
    tx_taken = 1'b1;
    @(negedge clk);
    tx_taken = 1'b0;
  endtask

  initial begin
    cts_n = 1'b1;
    expect_st(8'h08, "R3 cts visible in reset");
    cts_n = 1'b0;
    expect_st(8'h02, "R3 cts follows in reset");
    @(negedge clk);
    rst_n = 1'b1;
    expect_st(8'h02, "R11 reset state");

    rx_char(0, 0);
    expect_st(8'h03, "R2 load sets full");
    access(0, 1);
    expect_st(8'h03, "R1 status read no effect");
    cs_lo_n = 1'b1;
    access(1, 1);
    cs_lo_n = 1'b0;
    expect_st(8'h03, "R1 deselected low cs");
    cs_hi = 2'b10;
    access(1, 1);
    cs_hi = 2'b11;
    expect_st(8'h03, "R1 deselected high cs");
    bus_begin(1, 1);
    expect_st(8'h03, "R1 no effect before enable falls");
    bus_end();
    expect_st(8'h02, "R2 data read clears full");

    access(1, 0);
    expect_st(8'h00, "R3 write clears empty");
    tx_pulse();
    expect_st(8'h02, "R3 handoff sets empty");
    cts_n = 1'b1;
    expect_st(8'h08, "R3 cts high masks empty");
    cts_n = 1'b0;
    expect_st(8'h02, "R3 cts low unmasks");

    rx_char(1, 1);
    expect_st(8'h53, "R6 errors captured");
    parity_en = 1'b0;
    expect_st(8'h13, "R6 parity masked");
    parity_en = 1'b1;
    expect_st(8'h53, "R6 parity restored");
    access(1, 1);
    expect_st(8'h52, "R6 errors held after read");
    rx_char(0, 0);
    expect_st(8'h03, "R6 errors replaced on load");
    access(1, 1);
    expect_st(8'h02, "R2 read clears");

    rx_irq_en = 1'b1;
    rx_char(0, 0);
    expect_st(8'h83, "R8 full raises irq");
    rx_char(0, 0);
    expect_st(8'h83, "R7 overrun hidden");
    access(1, 1);
    expect_st(8'hA3, "R7 overrun shown after read");
    access(1, 1);
    expect_st(8'h02, "R7 second read clears");

    rx_char(0, 0);
    expect_st(8'h83, "R8 full");
    dcd_n = 1'b1;
    expect_st(8'h86, "R5 carrier loss hides full");
    dcd_n = 1'b0;
    expect_st(8'h87, "R4 dcd latched");
    access(1, 1);
    expect_st(8'h86, "R4 data read alone keeps latch");
    access(0, 1);
    access(1, 1);
    expect_st(8'h02, "R4 status then data read clears");
    dcd_n = 1'b1;
    expect_st(8'h86, "R8 dcd edge irq");
    access(0, 1);
    access(1, 1);
    expect_st(8'h06, "R4 bit follows input after clear");
    dcd_n = 1'b0;
    expect_st(8'h02, "R4 bit follows input low");
    rx_irq_en = 1'b0;

    tx_irq_en = 1'b1;
    expect_st(8'h82, "R9 tx irq");
    cts_n = 1'b1;
    expect_st(8'h08, "R9 cts removes tx irq");
    cts_n = 1'b0;
    expect_st(8'h82, "R9 tx irq back");
    access(1, 0);
    expect_st(8'h00, "R9 write removes tx irq");
    tx_pulse();
    expect_st(8'h82, "R9 handoff raises tx irq");
    tx_irq_en = 1'b0;
    expect_st(8'h02, "R9 enable off");

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule